// File: doc/BRIEF.md
# Two-Address Integer ALU with Stored Condition Flags

This block is the execute-stage arithmetic unit of a small 16-bit RISC core that uses two-address instructions. Each cycle it receives the destination register value, a second operand (either a source register or an 8-bit immediate from the instruction), and an operation code. It returns the value to write back into the destination register, plus a write-back enable. It also keeps a five-bit condition register holding overflow (F), unsigned-lower (L), carry/borrow (C), negative/signed-lower (N) and zero (Z).

The result path is purely combinational. The condition register is the only state, and it changes on a rising clock edge only when two things are both true: the caller asserts `flag_wr_en`, and the operation is add, subtract or compare. Add and subtract touch only C and F. Compare touches only Z, L and N. Compare performs the same subtraction as subtract but writes nothing back. Every other operation leaves the stored flags exactly as they were. The decode stage drives the opcode and the immediate-select bit. The branch logic reads `flags` directly.

Top module: `flag_alu`

## Requirements
- R1: Opcode 4'd0 (add) gives `result = dst_val + B` modulo 2^16. B is `src_val` when `use_imm` = 0. When `use_imm` = 1, B is `imm` sign-extended to 16 bits.
- R2: Opcode 4'd1 (subtract) gives `result = dst_val - B` modulo 2^16, with B chosen as in R1.
- R3: An add or subtract with `flag_wr_en` = 1 sets the flags at the next rising edge as follows. C (bit 2) takes the carry out for add, or the borrow (dst_val unsigned-below B) for subtract. F (bit 4) takes signed two's-complement overflow. L, N and Z are kept.
- R4: Opcode 4'd2 (compare) drives `wb_en` = 0. With `flag_wr_en` = 1 it loads three flags at the next edge. Z (bit 0) means dst_val == B. L (bit 3) means dst_val is unsigned-below B. N (bit 1) means dst_val is signed-below B. C and F are kept. B is chosen as in R1.
- R5: Opcodes 4'd3 (AND), 4'd4 (OR) and 4'd5 (XOR) apply the bitwise operation to dst_val and B. For these opcodes the immediate is zero-extended.
- R6: Opcode 4'd6 (move) gives `result = B`, with the immediate sign-extended.
- R7: Opcode 4'd7 (shift) moves dst_val by one bit position. The amount B is chosen as in R1. If B is negative (bit 15 set), the shift is a logical right shift. Otherwise it is a left shift, and a zero enters the vacated bit.
- R8: Opcode 4'd8 (load upper) gives `result = {imm, 8'h00}`, whatever the values of `use_imm` and `src_val`.
- R9: Opcodes 3 to 8 never change `flags`, even when `flag_wr_en` = 1. Add, subtract or compare with `flag_wr_en` = 0 leaves `flags` unchanged.
- R10: While `rst_n` is low, `flags` is 5'b00000 (bit order {F,L,C,N,Z} = bits 4..0).
- R11: Opcodes 4'd9 to 4'd15 give `result` = 0 and `wb_en` = 0, and do not change `flags`.
- R12: `wb_en` is 1 for opcodes 0, 1 and 3 through 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the condition register |
| rst_n | input | 1 | Asynchronous active-low reset of the condition register |
| op | input | 4 | Operation code |
| use_imm | input | 1 | Select the immediate instead of `src_val` as second operand |
| imm | input | 8 | Immediate field of the instruction |
| src_val | input | 16 | Source register value |
| dst_val | input | 16 | Destination register value (first operand) |
| flag_wr_en | input | 1 | Permit the condition register to update this cycle |
| result | output | 16 | Value to write back to the destination register |
| wb_en | output | 1 | Write-back of `result` is wanted |
| flags | output | 5 | Stored condition flags {F,L,C,N,Z} |

## Verification
The bench targets the boundaries where the flag meanings split. These are 0xFFFF + 1 (carry but no overflow), 0x7FFF + 1 (overflow but no carry), and compares of 0xFFFF against 1 in both orders, where the unsigned and signed orderings disagree. A design that used the wrong comparison for L or N, or that took the carry for subtract without inverting it, gives the opposite bit on one of these cases. Immediate 0x80 is used with both logic operations and arithmetic operations, so swapping zero extension and sign extension shows up as a wrong upper byte. The bench also issues compares after add and subtract operations that set C and F, and issues logic operations and undefined opcodes with the flag enable high. A block that let the wrong operation class write the wrong flag group would lose the earlier flags at those points.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_CMP = 4'd2,
    OP_AND = 4'd3,
    OP_OR  = 4'd4,
    OP_XOR = 4'd5,
    OP_MOV = 4'd6,
    OP_LSH = 4'd7,
    OP_LUI = 4'd8
  } alu_op_e;

  localparam int OP_W   = 4;
  localparam int FLAG_W = 5;

  // Bit positions inside the condition register.
  localparam int FB_Z = 0;
  localparam int FB_N = 1;
  localparam int FB_C = 2;
  localparam int FB_L = 3;
  localparam int FB_F = 4;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic [W-1:0] diff,
  output logic         carry,
  output logic         borrow,
  output logic         ovf_add,
  output logic         ovf_sub,
  output logic         eq,
  output logic         lt_u,
  output logic         lt_s
);

  function automatic logic [W:0] widen_add(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic [W:0] widen_sub(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x} - {1'b0, y};
  endfunction

  function automatic logic sgn_ovf_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                       input logic [W-1:0] r);
    return (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
  endfunction

  function automatic logic sgn_ovf_sub(input logic [W-1:0] x, input logic [W-1:0] y,
                                       input logic [W-1:0] r);
    return (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]);
  endfunction

  logic [W:0] add_full;
  logic [W:0] sub_full;

  always_comb begin
    add_full = widen_add(a, b);
    sub_full = widen_sub(a, b);
    sum      = add_full[W-1:0];
    diff     = sub_full[W-1:0];
    carry    = add_full[W];
    borrow   = sub_full[W];
    ovf_add  = sgn_ovf_add(a, b, add_full[W-1:0]);
    ovf_sub  = sgn_ovf_sub(a, b, sub_full[W-1:0]);
    eq       = (sub_full[W-1:0] == '0);
    lt_u     = sub_full[W];
    lt_s     = sub_full[W-1] ^ ovf_sub;
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W     = 16,
  parameter int IMM_W = 8
) (
  input  logic [3:0]       op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b_zx,
  input  logic [W-1:0]     b_sx,
  input  logic [IMM_W-1:0] imm,
  output logic [W-1:0]     y
);
  import alu_pkg::*;

  localparam int LOW_W = W - IMM_W;

  logic [W-1:0] upper_val;
  assign upper_val = {imm, {LOW_W{1'b0}}};

  always_comb begin
    case (alu_op_e'(op))
      OP_AND:  y = a & b_zx;
      OP_OR:   y = a | b_zx;
      OP_XOR:  y = a ^ b_zx;
      OP_MOV:  y = b_sx;
      OP_LUI:  y = upper_val;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] amt,
  output logic [W-1:0] y,
  output logic         going_right
);

  function automatic logic [W-1:0] step_left(input logic [W-1:0] x);
    return {x[W-2:0], 1'b0};
  endfunction

  function automatic logic [W-1:0] step_right(input logic [W-1:0] x);
    return {1'b0, x[W-1:1]};
  endfunction

  assign going_right = amt[W-1];
  assign y           = going_right ? step_right(a) : step_left(a);

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_cf,
  input  logic              upd_zln,
  input  logic              nxt_c,
  input  logic              nxt_f,
  input  logic              nxt_z,
  input  logic              nxt_l,
  input  logic              nxt_n,
  output logic [FLAG_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      if (upd_cf) begin
        q[FB_C] <= nxt_c;
        q[FB_F] <= nxt_f;
      end
      if (upd_zln) begin
        q[FB_Z] <= nxt_z;
        q[FB_L] <= nxt_l;
        q[FB_N] <= nxt_n;
      end
    end
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int W     = 16,
  parameter int IMM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op,
  input  logic             use_imm,
  input  logic [IMM_W-1:0] imm,
  input  logic [W-1:0]     src_val,
  input  logic [W-1:0]     dst_val,
  input  logic             flag_wr_en,
  output logic [W-1:0]     result,
  output logic             wb_en,
  output logic [4:0]       flags
);
  import alu_pkg::*;

  localparam int EXT_W = W - IMM_W;

  // Operand extension: variant picked by relative widths.
  logic [W-1:0] imm_sx;
  logic [W-1:0] imm_zx;
  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
      assign imm_zx = {{EXT_W{1'b0}}, imm};
    end else begin : g_noext
      assign imm_sx = imm[W-1:0];
      assign imm_zx = imm[W-1:0];
    end
  endgenerate

  logic [W-1:0] opnd_sx;
  logic [W-1:0] opnd_zx;
  assign opnd_sx = use_imm ? imm_sx : src_val;
  assign opnd_zx = use_imm ? imm_zx : src_val;

  // Named decode events.
  alu_op_e opc;
  logic    is_add, is_sub, is_cmp, is_arith, op_known;
  logic    upd_cf, upd_zln;
  assign opc      = alu_op_e'(op);
  assign is_add   = (opc == OP_ADD);
  assign is_sub   = (opc == OP_SUB);
  assign is_cmp   = (opc == OP_CMP);
  assign is_arith = is_add | is_sub | is_cmp;
  assign op_known = (op <= 4'(OP_LUI));
  assign upd_cf   = flag_wr_en & (is_add | is_sub);
  assign upd_zln  = flag_wr_en & is_cmp;

  // Arithmetic unit.
  logic [W-1:0] as_sum, as_diff;
  logic as_carry, as_borrow, as_ovf_add, as_ovf_sub, as_eq, as_lt_u, as_lt_s;

  alu_addsub #(.W(W)) u_addsub (
    .a       (dst_val),
    .b       (opnd_sx),
    .sum     (as_sum),
    .diff    (as_diff),
    .carry   (as_carry),
    .borrow  (as_borrow),
    .ovf_add (as_ovf_add),
    .ovf_sub (as_ovf_sub),
    .eq      (as_eq),
    .lt_u    (as_lt_u),
    .lt_s    (as_lt_s)
  );

  // Bitwise, move and load-upper.
  logic [W-1:0] lg_y;
  alu_logic #(.W(W), .IMM_W(IMM_W)) u_logic (
    .op   (op),
    .a    (dst_val),
    .b_zx (opnd_zx),
    .b_sx (opnd_sx),
    .imm  (imm),
    .y    (lg_y)
  );

  // Single-step shifter.
  logic [W-1:0] sh_y;
  logic         sh_right;
  alu_shift #(.W(W)) u_shift (
    .a           (dst_val),
    .amt         (opnd_sx),
    .y           (sh_y),
    .going_right (sh_right)
  );

  // Condition register.
  logic cf_c, cf_f;
  assign cf_c = is_sub ? as_borrow  : as_carry;
  assign cf_f = is_sub ? as_ovf_sub : as_ovf_add;

  logic [FLAG_W-1:0] flag_q;
  alu_flag_reg u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_cf  (upd_cf),
    .upd_zln (upd_zln),
    .nxt_c   (cf_c),
    .nxt_f   (cf_f),
    .nxt_z   (as_eq),
    .nxt_l   (as_lt_u),
    .nxt_n   (as_lt_s),
    .q       (flag_q)
  );
  assign flags = flag_q;

  // Result selection.
  always_comb begin
    case (opc)
      OP_ADD:                                 result = as_sum;
      OP_SUB:                                 result = as_diff;
      OP_LSH:                                 result = sh_y;
      OP_AND, OP_OR, OP_XOR, OP_MOV, OP_LUI:  result = lg_y;
      default:                                result = '0;
    endcase
  end

  assign wb_en = op_known & ~is_cmp;

  // Decode signals kept visible for debug; fold into an unused sink.
  logic unused_dbg;
  assign unused_dbg = ^{is_arith, sh_right};

endmodule

// File: rtl/flag_alu_checker.sv
module flag_alu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  op,
  input logic        use_imm,
  input logic [15:0] src_val,
  input logic [15:0] dst_val,
  input logic        flag_wr_en,
  input logic [15:0] result,
  input logic        wb_en,
  input logic [4:0]  flags
);

  logic arith_op;
  assign arith_op = (op == 4'd0) || (op == 4'd1) || (op == 4'd2);

  // R4: compare never requests write-back
  p_cmp_no_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd2) |-> !wb_en);

  // R4: compare with register operand loads Z from equality
  p_cmp_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd2 && !use_imm && flag_wr_en) |=> (flags[0] == ($past(dst_val) == $past(src_val))));

  // R4: compare keeps C and F
  p_cmp_keeps_cf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd2) |=> (flags[4] == $past(flags[4]) && flags[2] == $past(flags[2])));

  // R3: add and subtract keep L, N and Z
  p_addsub_keeps_zln_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd0 || op == 4'd1) |=> (flags[3] == $past(flags[3]) && flags[1:0] == $past(flags[1:0])));

  // R9: no update unless enabled arithmetic
  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_wr_en || !arith_op) |=> $stable(flags));

  // R6: register move copies the source
  p_mov_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd6 && !use_imm) |-> (result == src_val));

  // R11: undefined opcodes are inert
  p_undef_inert_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op > 4'd8) |-> (!wb_en && result == 16'h0000));

  // R10: reset clears the condition register
  p_reset_clear_r10: assert property (@(posedge clk)
    !rst_n |=> (flags == 5'b00000));

endmodule

bind flag_alu flag_alu_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op         (op),
  .use_imm    (use_imm),
  .src_val    (src_val),
  .dst_val    (dst_val),
  .flag_wr_en (flag_wr_en),
  .result     (result),
  .wb_en      (wb_en),
  .flags      (flags)
);

// File: tb/flag_alu_tb.sv
`timescale 1ns/1ps
module flag_alu_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = 4'd0;
  logic        use_imm = 1'b0;
  logic [7:0]  imm = 8'h00;
  logic [15:0] src_val = 16'h0000;
  logic [15:0] dst_val = 16'h0000;
  logic        flag_wr_en = 1'b0;
  logic [15:0] result;
  logic        wb_en;
  logic [4:0]  flags;

  always #2 clk = ~clk;

  flag_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op(op), .use_imm(use_imm), .imm(imm),
    .src_val(src_val), .dst_val(dst_val), .flag_wr_en(flag_wr_en),
    .result(result), .wb_en(wb_en), .flags(flags)
  );

  typedef struct packed {
    logic [15:0] res;
    logic        wb;
    logic [4:0]  flg;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  logic [4:0] mflags = 5'b0;   // {F,L,C,N,Z}

  // Reference model, written from the requirements.
  task automatic model(input int o, input bit ui, input logic [7:0] iv,
                       input logic [15:0] s, input logic [15:0] d, input bit fw,
                       output logic [15:0] r, output bit w);
    int b_s, b_z, ds, bs, tmp;
    b_s = ui ? int'($signed(iv)) & 32'hFFFF : int'(s);
    b_z = ui ? int'(iv) : int'(s);
    ds  = int'($signed(d));
    bs  = (b_s >= 32768) ? b_s - 65536 : b_s;
    r = 16'h0; w = 1'b1;
    case (o)
      0: begin
        tmp = int'(d) + b_s; r = tmp[15:0];
        if (fw) begin mflags[2] = (tmp > 65535); mflags[4] = ((ds + bs) > 32767) || ((ds + bs) < -32768); end
      end
      1: begin
        tmp = int'(d) - b_s; r = tmp[15:0];
        if (fw) begin mflags[2] = (tmp < 0); mflags[4] = ((ds - bs) > 32767) || ((ds - bs) < -32768); end
      end
      2: begin
        w = 1'b0;
        if (fw) begin mflags[0] = (int'(d) == b_s); mflags[3] = (int'(d) < b_s); mflags[1] = (ds < bs); end
      end
      3: r = d & b_z[15:0];
      4: r = d | b_z[15:0];
      5: r = d ^ b_z[15:0];
      6: r = b_s[15:0];
      7: r = (bs < 0) ? (d / 2) : ((d * 2) & 16'hFFFF);
      8: r = {iv, 8'h00};
      default: begin r = 16'h0; w = 1'b0; end
    endcase
  endtask

  task automatic drive(input string tag, input int o, input bit ui, input logic [7:0] iv,
                       input logic [15:0] s, input logic [15:0] d, input bit fw);
    logic [15:0] r; bit w; exp_t e;
    @(negedge clk);
    op = o[3:0]; use_imm = ui; imm = iv; src_val = s; dst_val = d; flag_wr_en = fw;
    model(o, ui, iv, s, d, fw, r, w);
    e.res = r; e.wb = w; e.flg = mflags;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: results settle before the edge, flags update at it.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e; string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (wb_en !== e.wb || (e.wb && result !== e.res) || flags !== e.flg) begin
        n_bad++;
        $display("FAIL %s: result=%h wb=%b flags=%b expected result=%h wb=%b flags=%b",
                 t, result, wb_en, flags, e.res, e.wb, e.flg);
      end
    end
  end

  task automatic check_reset(input string tag);
    n_chk++;
    if (flags !== 5'b00000) begin
      n_bad++;
      $display("FAIL %s: flags=%b expected=%b", tag, flags, 5'b00000);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #30000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] x, y;
    repeat (3) @(posedge clk);
    #1 check_reset("R10 reset");
    @(negedge clk); rst_n = 1'b1;

    drive("R1 add reg", 0, 0, 8'h00, 16'h0003, 16'h0004, 1);
    drive("R3 add carry", 0, 0, 8'h00, 16'h0001, 16'hFFFF, 1);
    drive("R3 add ovf", 0, 0, 8'h00, 16'h0001, 16'h7FFF, 1);
    drive("R1 addi neg", 0, 1, 8'hFF, 16'h1234, 16'h0005, 1);
    drive("R2 sub", 1, 0, 8'h00, 16'h0003, 16'h0005, 1);
    drive("R3 sub borrow", 1, 0, 8'h00, 16'h0005, 16'h0003, 1);
    drive("R3 sub ovf", 1, 0, 8'h00, 16'h0001, 16'h8000, 1);
    drive("R4 cmp eq", 2, 0, 8'h00, 16'h1234, 16'h1234, 1);
    drive("R4 cmp signed", 2, 0, 8'h00, 16'h0001, 16'hFFFF, 1);
    drive("R4 cmp unsigned", 2, 0, 8'h00, 16'hFFFF, 16'h0001, 1);
    drive("R4 cmpi", 2, 1, 8'h80, 16'h0000, 16'hFF80, 1);
    drive("R5 and imm", 3, 1, 8'h80, 16'h0000, 16'hFFFF, 1);
    drive("R5 or imm", 4, 1, 8'h80, 16'h0000, 16'h1200, 1);
    drive("R5 xor reg", 5, 0, 8'h00, 16'h0F0F, 16'hFFFF, 1);
    drive("R6 mov reg", 6, 0, 8'h00, 16'hBEEF, 16'h0000, 1);
    drive("R6 movi", 6, 1, 8'h80, 16'h0000, 16'h0000, 1);
    drive("R7 lsh left", 7, 0, 8'h00, 16'h0001, 16'h8001, 1);
    drive("R7 lsh right", 7, 0, 8'h00, 16'hFFFF, 16'h8001, 1);
    drive("R7 lshi right", 7, 1, 8'hFF, 16'h0000, 16'h0006, 1);
    drive("R7 lsh zero", 7, 0, 8'h00, 16'h0000, 16'h4000, 1);
    drive("R8 lui", 8, 0, 8'hAB, 16'hFFFF, 16'h5555, 1);
    drive("R9 add no enable", 0, 0, 8'h00, 16'h0001, 16'hFFFF, 0);
    drive("R9 cmp no enable", 2, 0, 8'h00, 16'h0002, 16'h0002, 0);
    drive("R11 undef op", 9, 0, 8'h00, 16'h1111, 16'h2222, 1);
    drive("R11 undef op15", 15, 1, 8'h7F, 16'h1111, 16'h2222, 1);
    drive("R12 mov wb", 6, 1, 8'h01, 16'h0000, 16'h0000, 0);
    for (int i = 0; i < 60; i++) begin
      x = 16'(i * 16'h2F1B + 16'h7FF0);
      y = 16'(i * 16'h1D37 + 16'hFFF0);
      drive("R3 sweep", i % 9, i[2], x[7:0], x, y, 1);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b0; mflags = 5'b0;
    #1 check_reset("R10 mid-run reset");
    @(negedge clk); rst_n = 1'b1;
    drive("R10 post reset", 3, 0, 8'h00, 16'h00FF, 16'h0F0F, 1);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule